// File: doc/BRIEF.md
# Three-Phase Half-Bridge Gate Control

This block sits between a motor controller's PWM outputs and the gate drivers of three half bridges. Each phase has an upper and a lower switch. For each phase the block takes an upper-on command and a lower-on command, passes both through a two-flop synchronizer, and decodes the pair into one of three switch states. It inserts a programmable dead time whenever a switch turns off. This keeps the opposite switch of that phase from turning on until the outgoing one has had time to go off.

On top of the per-phase decode sit several shutdown sources, all of which force every gate off:
- either of two supply-undervoltage flags;
- a dedicated disable input;
- an external force on the shared limit/disable line;
- a cycle-by-cycle current-limit latch.

The latch sets when any of three over-current comparator flags is high. It is cleared only by a rising edge on an upper-switch command in a cycle with no over-current flag.

The shared limit/disable line is modelled as three signals:
- the block's own flag output, which is the latch state;
- an enable showing that the line is being forced from outside;
- the forced level.

A forced high disables all gates. A forced low defeats the current limit.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: With upper command 1 and lower command 0, the phase's upper gate (bit p of `gate_hi`) turns on. With upper 0 and lower 1, only the lower gate (`gate_lo`) turns on. From an idle phase this happens on the third rising clock edge after the command changes.
- R2: With both commands 0, or both commands 1, both gates of that phase stay off.
- R3: After a gate of a phase turns off, the opposite gate of that phase turns on no sooner than DEAD+1 cycles later. With DEAD=8, a direct upper-to-lower command change gives lower-on at the 12th edge and all-off at the 11th.
- R4: When any bit of `oc_flag` is high and the limit is not defeated, `lim_flag` is high from the next edge, and all six gates are off while it is high.
- R5: `lim_flag` stays high while the commands are steady, even after `oc_flag` clears. It clears on the edge at which a synchronized upper command rises, but only if no `oc_flag` bit is high in that cycle.
- R6: With `lim_ext_en`=1 and `lim_ext_val`=1, all gates are off.
- R7: With `lim_ext_en`=1 and `lim_ext_val`=0, `oc_flag` is ignored: `lim_flag` stays 0 and the gates follow the commands.
- R8: With `dis_in`=1, all gates are off regardless of the commands.
- R9: With either bit of `uv_flag` high, all gates are off, and `lim_flag` is not affected.
- R10: After reset, all gates are off and `lim_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_hi | input | PHASES | Upper-switch on command per phase (asynchronous) |
| cmd_lo | input | PHASES | Lower-switch on command per phase (asynchronous) |
| oc_flag | input | PHASES | Over-current comparator flags, synchronous |
| uv_flag | input | UVN | Supply-undervoltage flags |
| dis_in | input | 1 | Disable input, high turns all gates off |
| lim_ext_en | input | 1 | The shared limit/disable line is forced from outside |
| lim_ext_val | input | 1 | Forced level of the shared line |
| lim_flag | output | 1 | Current-limit latch state driven onto the shared line |
| gate_hi | output | PHASES | Upper gate enables |
| gate_lo | output | PHASES | Lower gate enables |

## Verification
The assertions assume that `oc_flag` is already synchronous to `clk`. They also assume that the shutdown inputs are free of glitches within a cycle. The bench changes every input only at the falling clock edge, so each input is stable across the following rising edge. The bench measures dead-time and limit-release timing from a phase that has been idle or steady for at least 20 cycles, so that no earlier dead-time count is still running when a measurement starts.

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl #(
  parameter int PHASES = 3,
  parameter int DEAD   = 8,
  parameter int UVN    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] cmd_hi,
  input  logic [PHASES-1:0] cmd_lo,
  input  logic [PHASES-1:0] oc_flag,
  input  logic [UVN-1:0]    uv_flag,
  input  logic              dis_in,
  input  logic              lim_ext_en,
  input  logic              lim_ext_val,
  output logic              lim_flag,
  output logic [PHASES-1:0] gate_hi,
  output logic [PHASES-1:0] gate_lo
);
  localparam int CW = $clog2(DEAD + 1) + 1;
  typedef enum logic [1:0] {SW_OFF, SW_UP, SW_DN} sw_t;

  logic [PHASES-1:0] hi_m, hi_s, hi_d, lo_m, lo_s;
  logic              lim_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_m <= '0; hi_s <= '0; hi_d <= '0; lo_m <= '0; lo_s <= '0;
    end else begin
      hi_m <= cmd_hi; hi_s <= hi_m; hi_d <= hi_s;
      lo_m <= cmd_lo; lo_s <= lo_m;
    end

  wire oc_any   = |oc_flag;
  wire defeat   = lim_ext_en & ~lim_ext_val;
  wire ext_off  = lim_ext_en & lim_ext_val;
  wire rise_any = |(hi_s & ~hi_d);
  wire kill     = (|uv_flag) | dis_in | ext_off | lim_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        lim_q <= 1'b0;
    else if (defeat)   lim_q <= 1'b0;
    else if (oc_any)   lim_q <= 1'b1;
    else if (rise_any) lim_q <= 1'b0;

  assign lim_flag = lim_q;

  for (genvar p = 0; p < PHASES; p++) begin : g_ph
    sw_t           st;
    logic [CW-1:0] cnt;
    sw_t           want;

    always_comb begin
      want = SW_OFF;
      if (hi_s[p] & ~lo_s[p]) want = SW_UP;
      else if (lo_s[p] & ~hi_s[p]) want = SW_DN;
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        st  <= SW_OFF;
        cnt <= '0;
      end else if (want != st) begin
        if (st != SW_OFF) begin
          st  <= SW_OFF;
          cnt <= CW'(DEAD);
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          st <= want;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end

    assign gate_hi[p] = ~kill & (st == SW_UP);
    assign gate_lo[p] = ~kill & (st == SW_DN);
  end

  a_r3_no_direct_swap: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi & $past(gate_lo)) == '0) && ((gate_lo & $past(gate_hi)) == '0));

  a_r4_limit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_any && !defeat) |=> (lim_flag && gate_hi == '0 && gate_lo == '0));

  a_r5_limit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_flag && !oc_any && !rise_any && !defeat) |=> lim_flag);

  a_r7_defeat_clears: assert property (@(posedge clk) disable iff (!rst_n)
    defeat |=> !lim_flag);

  a_r8_dis_off: assert property (@(posedge clk) disable iff (!rst_n)
    dis_in |-> ((gate_hi | gate_lo) == '0));

  a_r9_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
    (|uv_flag) |-> ((gate_hi | gate_lo) == '0));
endmodule

// File: tb/bridge_gate_ctrl_bench.sv
module bridge_gate_ctrl_bench;
  localparam int D = 8;
  logic clk = 0, rst_n = 0;
  logic [2:0] cmd_hi = 0, cmd_lo = 0, oc_flag = 0;
  logic [1:0] uv_flag = 0;
  logic dis_in = 0, lim_ext_en = 0, lim_ext_val = 0;
  logic lim_flag;
  logic [2:0] gate_hi, gate_lo;
  int checks = 0, errors = 0;

  bridge_gate_ctrl #(.PHASES(3), .DEAD(D), .UVN(2)) u_bridge_gate_ctrl (
    .clk, .rst_n, .cmd_hi, .cmd_lo, .oc_flag, .uv_flag, .dis_in,
    .lim_ext_en, .lim_ext_val, .lim_flag, .gate_hi, .gate_lo);

  always #5 clk = ~clk;

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] eh, input logic [2:0] el, input logic elim);
    checks++;
    if (gate_hi !== eh || gate_lo !== el || lim_flag !== elim) begin
      errors++;
      $display("FAIL %s: hi=%b lo=%b lim=%b expected hi=%b lo=%b lim=%b",
               req, gate_hi, gate_lo, lim_flag, eh, el, elim);
    end
  endtask

  task automatic t_reset;
    rst_n = 0; wait_n(2);
    chk("R10 in reset", 3'b000, 3'b000, 1'b0);
    rst_n = 1; wait_n(3);
    chk("R10 after reset", 3'b000, 3'b000, 1'b0);
  endtask

  task automatic t_illegal;
    cmd_hi = 3'b111; cmd_lo = 3'b111; wait_n(20);
    chk("R2 both high", 3'b000, 3'b000, 1'b0);
    cmd_hi = 3'b000; cmd_lo = 3'b000; wait_n(20);
    chk("R2 both low", 3'b000, 3'b000, 1'b0);
  endtask

  task automatic t_decode;
    cmd_hi = 3'b001; cmd_lo = 3'b010; wait_n(2);
    chk("R1 latency not yet", 3'b000, 3'b000, 1'b0);
    wait_n(1);
    chk("R1 decode", 3'b001, 3'b010, 1'b0);
    cmd_hi = 3'b000; cmd_lo = 3'b000; wait_n(20);
  endtask

  task automatic t_dead;
    cmd_hi = 3'b001; wait_n(20);
    chk("R1 upper on", 3'b001, 3'b000, 1'b0);
    cmd_hi = 3'b000; cmd_lo = 3'b001; wait_n(3 + D);
    chk("R3 dead gap", 3'b000, 3'b000, 1'b0);
    wait_n(1);
    chk("R3 lower after dead", 3'b000, 3'b001, 1'b0);
  endtask

  task automatic t_limit;
    cmd_hi = 3'b010; wait_n(20);
    chk("R1 mixed", 3'b010, 3'b001, 1'b0);
    oc_flag = 3'b100; wait_n(1);
    chk("R4 limit set", 3'b000, 3'b000, 1'b1);
    oc_flag = 3'b000; wait_n(20);
    chk("R5 held at full duty", 3'b000, 3'b000, 1'b1);
    cmd_hi = 3'b110; wait_n(2);
    chk("R5 before edge", 3'b000, 3'b000, 1'b1);
    wait_n(1);
    chk("R5 released by rising top", 3'b110, 3'b001, 1'b0);
    oc_flag = 3'b001; wait_n(1);
    cmd_hi = 3'b010; wait_n(20);
    cmd_hi = 3'b110; wait_n(20);
    chk("R5 edge blocked by active flag", 3'b000, 3'b000, 1'b1);
    oc_flag = 3'b000; wait_n(20);
    chk("R5 still held", 3'b000, 3'b000, 1'b1);
    cmd_hi = 3'b010; wait_n(20);
    cmd_hi = 3'b110; wait_n(20);
    chk("R5 released later", 3'b110, 3'b001, 1'b0);
  endtask

  task automatic t_ext;
    lim_ext_en = 1; lim_ext_val = 1; wait_n(1);
    chk("R6 forced high", 3'b000, 3'b000, 1'b0);
    lim_ext_en = 0; wait_n(1);
    chk("R6 release", 3'b110, 3'b001, 1'b0);
    lim_ext_en = 1; lim_ext_val = 0; oc_flag = 3'b111; wait_n(5);
    chk("R7 limit defeated", 3'b110, 3'b001, 1'b0);
    oc_flag = 3'b000; wait_n(1);
    lim_ext_en = 0; wait_n(2);
    chk("R7 after release", 3'b110, 3'b001, 1'b0);
  endtask

  task automatic t_dis_uv;
    dis_in = 1; wait_n(1);
    chk("R8 disable", 3'b000, 3'b000, 1'b0);
    dis_in = 0; wait_n(1);
    chk("R8 release", 3'b110, 3'b001, 1'b0);
    uv_flag = 2'b10; wait_n(1);
    chk("R9 uv bit1", 3'b000, 3'b000, 1'b0);
    uv_flag = 2'b01; wait_n(1);
    chk("R9 uv bit0", 3'b000, 3'b000, 1'b0);
    uv_flag = 2'b00; wait_n(1);
    chk("R9 release", 3'b110, 3'b001, 1'b0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset(); t_illegal(); t_decode(); t_dead();
        t_limit(); t_ext(); t_dis_uv();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule